// File: doc/BRIEF.md
# Metastability Bias Feedback Controller

This block closes the control loop around a sampling flip-flop whose data input races its clock. The flip-flop's resolved bit arrives on `bit_in` each cycle. An up/down counter keeps a running sum of the stream: every 1 adds one and every 0 subtracts one. The counter's low field sets a fine tuning weight and its high field sets a coarse tuning weight. Each weight is decoded into a pair of thermometer words, one for the top delay path and one for the bottom delay path. These words drive the control inputs of two sets of delay lines. When the stream leans towards 1, the counter rises and moves the weights until the sampled race is balanced again.

Each field is decoded in sign-and-magnitude form. The field's top bit selects which path's word carries ones, and the remaining bits set how many. The resulting weight is the number of ones in the top word minus the number of ones in the bottom word. It is never zero, and it increases as the field value increases. The delay lines and the flip-flop are outside the block. Each raw bit is passed on together with the counter value whose decoded weights were on the delay controls while that bit was being sampled, so a later stage can grade or filter it.

Top module: `meta_bias_loop`

## Requirements
- R1: While `en` is high, a sampled 1 raises the counter by one on the clock edge, unless the counter is at its maximum.
- R2: While `en` is high, a sampled 0 lowers the counter by one on the clock edge, unless the counter is at zero.
- R3: Reset (asynchronous, active low) loads the counter with all ones (4095) and sets `bit_out` to 0 and `bit_tag` to 4095. Both sets of words then show weight +32: every top-word bit is 1 and every bottom-word bit is 0.
- R4: Counter bits [5:0] form the fine field and drive `fine_top`/`fine_bot`. Bits [11:6] form the coarse field and drive `coarse_top`/`coarse_bot`.
- R5: When a field's bit 5 is 1 with low bits m, the top word has ones in bits 0..m (m+1 ones), the bottom word is zero, and the weight is +(m+1).
- R6: When a field's bit 5 is 0 with low bits m, the bottom word has ones in bits 0..(31-m) (inverted m plus one), the top word is zero, and the weight is -(32-m). Examples: 000000 gives -32, 011111 gives -1, 100000 gives +1, 111111 gives +32.
- R7: Weight = ones in top word minus ones in bottom word. It lies in [-32,+32], is never zero, and rises by one per field step except across the sign change (-1 to +1).
- R8: The counter saturates: a 1 at 4095 keeps it at 4095, and a 0 at 0 keeps it at 0.
- R9: While `en` is low, `bit_in` has no effect on the counter or on any thermometer word.
- R10: After each edge, `bit_out` holds the bit sampled at that edge. `bit_tag` holds the counter value whose decode was on the thermometer outputs during the preceding cycle.
- R11: In closed loop with a delay model that gives 1 when the effective delay difference is below a small band and 0 above it, the counter settles from 4095 into a narrow steady band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter update enable |
| bit_in | input | 1 | Resolved bit from the racing flip-flop |
| fine_top | output | 32 | Top-path thermometer word, fine set |
| fine_bot | output | 32 | Bottom-path thermometer word, fine set |
| coarse_top | output | 32 | Top-path thermometer word, coarse set |
| coarse_bot | output | 32 | Bottom-path thermometer word, coarse set |
| bit_out | output | 1 | Registered raw bit |
| bit_tag | output | 12 | Counter value that drove the delays while `bit_out` was sampled |

## Verification
The assertions assume that `bit_in` is a clean, settled 0 or 1 at each clock edge. Metastability has already resolved upstream, so no unknown value reaches the counter. They also assume that `en` changes only between edges. The bench drives both inputs at the falling edge from a deterministic model. In closed loop, that model derives the bit from the thermometer words it read half a cycle earlier. Outside a band of two delay steps around zero the model is strictly deterministic, so the settled band it expects can be computed exactly.

// File: rtl/meta_bias_loop.sv
module meta_bias_loop #(
  parameter int CNT_W  = 12,
  parameter int FINE_W = 6,
  localparam int COARSE_W = CNT_W - FINE_W,
  localparam int FINE_N   = 2 ** (FINE_W - 1),
  localparam int COARSE_N = 2 ** (COARSE_W - 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                bit_in,
  output logic [FINE_N-1:0]   fine_top,
  output logic [FINE_N-1:0]   fine_bot,
  output logic [COARSE_N-1:0] coarse_top,
  output logic [COARSE_N-1:0] coarse_bot,
  output logic                bit_out,
  output logic [CNT_W-1:0]    bit_tag
);
  localparam int FM = FINE_W - 1;
  localparam int CM = COARSE_W - 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [FINE_N-1:0] ft_d, fb_d;
  logic [COARSE_N-1:0] ct_d, cb_d;

  wire at_top = (cnt == CMAX);
  wire at_bot = (cnt == '0);

  always_comb begin
    cnt_nx = cnt;
    if (en) begin
      if (bit_in && !at_top)      cnt_nx = cnt + 1'b1;
      else if (!bit_in && !at_bot) cnt_nx = cnt - 1'b1;
    end
  end

  wire [FINE_W-1:0]   f_nx = cnt_nx[FINE_W-1:0];
  wire [COARSE_W-1:0] c_nx = cnt_nx[CNT_W-1:FINE_W];

  for (genvar k = 0; k < FINE_N; k++) begin : g_fine
    assign ft_d[k] =  f_nx[FM] & (f_nx[FM-1:0]  >= FM'(k));
    assign fb_d[k] = ~f_nx[FM] & (~f_nx[FM-1:0] >= FM'(k));
  end

  for (genvar k = 0; k < COARSE_N; k++) begin : g_coarse
    assign ct_d[k] =  c_nx[CM] & (c_nx[CM-1:0]  >= CM'(k));
    assign cb_d[k] = ~c_nx[CM] & (~c_nx[CM-1:0] >= CM'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= CMAX;
      fine_top   <= '1;
      fine_bot   <= '0;
      coarse_top <= '1;
      coarse_bot <= '0;
      bit_out    <= 1'b0;
      bit_tag    <= CMAX;
    end else begin
      cnt        <= cnt_nx;
      fine_top   <= ft_d;
      fine_bot   <= fb_d;
      coarse_top <= ct_d;
      coarse_bot <= cb_d;
      bit_out    <= bit_in;
      bit_tag    <= cnt;
    end
  end
endmodule

// File: rtl/meta_bias_loop_chk.sv
module meta_bias_loop_chk #(
  parameter int CNT_W  = 12,
  parameter int FINE_W = 6,
  localparam int COARSE_W = CNT_W - FINE_W,
  localparam int FINE_N   = 2 ** (FINE_W - 1),
  localparam int COARSE_N = 2 ** (COARSE_W - 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                bit_in,
  input logic [CNT_W-1:0]    cnt,
  input logic [FINE_N-1:0]   fine_top,
  input logic [FINE_N-1:0]   fine_bot,
  input logic [COARSE_N-1:0] coarse_top,
  input logic [COARSE_N-1:0] coarse_bot,
  input logic                bit_out,
  input logic [CNT_W-1:0]    bit_tag
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bit_in && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1);

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_in && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // R8
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_in && cnt == CMAX) |=> cnt == CMAX);

  // R8
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_in && cnt == '0) |=> cnt == '0);

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt) && $stable(fine_top) && $stable(fine_bot)
            && $stable(coarse_top) && $stable(coarse_bot));

  // R10
  tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bit_tag == $past(cnt) && bit_out == $past(bit_in));

  // R5
  path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|fine_top && |fine_bot) || (|coarse_top && |coarse_bot)));

  // R7
  nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fine_top || |fine_bot) && (|coarse_top || |coarse_bot));

  // R6
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fine_top & FINE_N'(fine_top + 1'b1)) == '0)
    && ((fine_bot & FINE_N'(fine_bot + 1'b1)) == '0));

  // R4
  fine_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[FINE_W-1] |-> $countones(fine_top) == int'(cnt[FINE_W-2:0]) + 1);
endmodule

bind meta_bias_loop meta_bias_loop_chk #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_chk (.*);

// File: tb/sim_meta_bias_loop.sv
module sim_meta_bias_loop;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, bit_in = 1'b0;
  logic [N-1:0] fine_top, fine_bot, coarse_top, coarse_bot;
  logic bit_out;
  logic [11:0] bit_tag;
  int checks = 0, errors = 0;
  int mc = 4095;

  always #5 clk = ~clk;

  meta_bias_loop u0 (.clk, .rst_n, .en, .bit_in, .fine_top, .fine_bot,
                     .coarse_top, .coarse_bot, .bit_out, .bit_tag);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dec(input int f);
    int m = f % 32;
    logic [63:0] w;
    if (f >= 32) w = ((64'd1 << (m + 1)) - 64'd1) << 32;
    else         w = (64'd1 << (32 - m)) - 64'd1;
    return w;
  endfunction

  function automatic int wexp(input int f);
    return (f >= 32) ? f - 31 : f - 32;
  endfunction

  function automatic int wport(input logic [N-1:0] t, input logic [N-1:0] b);
    return $countones(t) - $countones(b);
  endfunction

  task automatic check_words(input string req);
    check({fine_top, fine_bot} == dec(mc % 64), {req, " R4 R5 R6 fine"},
          {fine_top, fine_bot}, dec(mc % 64));
    check({coarse_top, coarse_bot} == dec(mc / 64), {req, " R4 coarse"},
          {coarse_top, coarse_bot}, dec(mc / 64));
    check(wport(fine_top, fine_bot) == wexp(mc % 64), "R7 fine weight",
          wport(fine_top, fine_bot), wexp(mc % 64));
  endtask

  task automatic step(input logic b, input logic e, input string req);
    int old;
    bit_in = b; en = e;
    @(posedge clk);
    old = mc;
    if (e) begin
      if (b && mc < 4095) mc++;
      else if (!b && mc > 0) mc--;
    end
    @(negedge clk);
    check(bit_tag == 12'(old), "R10 tag", bit_tag, old);
    check(bit_out == b, "R10 bit", bit_out, b);
    check_words(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    mc = 4095;
    check(bit_tag == 12'd4095 && bit_out == 1'b0, "R3 tag/bit", {bit_tag, bit_out}, {12'd4095, 1'b0});
    check(fine_top == '1 && fine_bot == '0 && coarse_top == '1 && coarse_bot == '0,
          "R3 words", {fine_top, coarse_bot}, {32'hffffffff, 32'h0});
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_descend;
    for (int i = 0; i < 4095; i++) step(1'b0, 1'b1, "R2 descend");
    check(bit_tag == 12'd1 && mc == 0, "R2 floor reached", bit_tag, 1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R8 floor");
    check(wport(fine_top, fine_bot) == -32 && wport(coarse_top, coarse_bot) == -32,
          "R6 all-zero field weight", wport(fine_top, fine_bot), -32);
  endtask

  task automatic t_ascend;
    for (int i = 0; i < 4095; i++) begin
      step(1'b1, 1'b1, "R1 ascend");
      if (mc == 31) check(wport(fine_top, fine_bot) == -1, "R6 field 011111", wport(fine_top, fine_bot), -1);
      if (mc == 32) check(wport(fine_top, fine_bot) == 1, "R5 field 100000", wport(fine_top, fine_bot), 1);
    end
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R8 ceiling");
    check(bit_tag == 12'd4095, "R8 ceiling held", bit_tag, 4095);
  endtask

  task automatic t_freeze;
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, "R2 pre-freeze");
    for (int i = 0; i < 20; i++) step(logic'(i % 3 == 0), 1'b0, "R9 frozen");
    check(bit_tag == 12'd4055, "R9 counter held", bit_tag, 4055);
    step(1'b1, 1'b1, "R1 resume");
  endtask

  task automatic t_closed;
    int bad = 0, ones = 0, eff;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; en = 1'b1;
    for (int i = 0; i < 9000; i++) begin
      eff = 16 * wport(coarse_top, coarse_bot) + wport(fine_top, fine_bot);
      if (eff < -2)     bit_in = 1'b1;
      else if (eff > 2) bit_in = 1'b0;
      else              bit_in = logic'($urandom % 2);
      @(negedge clk);
      if (i >= 8000) begin
        if (bit_tag < 12'd2061 || bit_tag > 12'd2067) bad++;
        if (bit_out) ones++;
      end
    end
    check(bad == 0, "R11 settled band", bad, 0);
    check(ones > 0 && ones < 1000, "R11 mixed bits", ones, 500);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_descend;
    t_ascend;
    t_freeze;
    t_closed;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule